// File: doc/BRIEF.md
# Segmented Data Memory Address Unit

This block turns one data-memory access request into a physical RAM address and carries out the access. The 8-bit effective address comes either straight from the request or from one of three pointer registers (B, X, stack pointer). Addresses with bit 7 clear sit in a 128-byte window that the segment register banks into 256 segments. Addresses with bit 7 set pass through without extension. The sixteen addresses at the top of the 8-bit range hold a small register file built from flops. The pointers and the segment register are part of that file, so ordinary loads and stores at fixed addresses read and write them.

A B or X indirect access may ask for a post-increment or post-decrement of the pointer it used. The pointer changes after the access. A RAM model of `RAM_BYTES` bytes sits behind the translator. A physical address past its end reads as zero and drops writes. Read data comes back one cycle after the request. The physical address of the current request is also driven on a port for observation.

Top module: `segaddr_unit`

## Requirements
- R1: A synchronous active-low reset sets the stack pointer (address FD) to `SP_RESET` (default 6F) and clears B (FE), X (FC), S (FF) and the other register-file bytes. While reset is held, `rd_valid` stays low.
- R2: An effective address with bit 7 set (80..FF) maps to physical address {zeros, addr}, whatever the value of S.
- R3: An effective address with bit 7 clear (00..7F) maps to physical address {S, addr[6:0]}, with 8 segment bits above 7 offset bits (15 bits in total).
- R4: Effective addresses F0..FF read and write the 16-byte register file and never touch RAM. RAM bytes at physical F0..FF can only be reached through a segment (for example S=1, address 70..7F).
- R5: The register file maps X at FC, SP at FD, B at FE and S at FF. Writing one of these addresses loads that register, and reading it returns that register's value.
- R6: `req_mode` picks the source of the effective address: 00 takes `req_addr` directly, 01 takes B, 10 takes X, 11 takes SP.
- R7: On an indirect access through B or X, `req_postmod` 01 increments the pointer and 10 decrements it, modulo 256. The access itself uses the pointer's value from before the change.
- R8: `req_postmod` has no effect in direct and SP modes, and the code 11 has no effect in any mode.
- R9: If an access writes a pointer's own mapped address while it post-modifies that same pointer, the pointer takes the written data.
- R10: A physical address at or above `RAM_BYTES` reads as 00 and ignores writes.
- R11: `rd_valid` pulses high for exactly the cycle after each read request, and `rd_data` is valid in that cycle. Write requests do not raise `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | Address source: 00 direct, 01 B, 10 X, 11 SP |
| req_postmod | input | 2 | Pointer post-modify: 01 increment, 10 decrement, other none |
| req_addr | input | 8 | Direct address (used in mode 00) |
| req_wdata | input | 8 | Write data |
| phys_addr | output | 15 | Physical address of the current request |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | 8 | Read data |

## Verification
The bench uses the default parameters: 512 bytes of RAM, an 8-bit segment register and a stack-pointer reset of 6F. With 512 bytes, segments 0 to 3 land in real RAM, so the bench can check data isolation between segments and the last in-range byte at physical 1FF. Setting S to 4 moves the lower window past the end of RAM, which brings the read-as-zero and dropped-write behaviour within reach. Segment 1 overlays physical F0..FF, which lets the bench show that those RAM bytes stay separate from the register file.

// File: rtl/segaddr_pkg.sv
// Package: shared encodings for the segmented data memory address unit.
// Assumes an 8-bit data path and a 16-entry register file at the top of
// the 8-bit address range.
package segaddr_pkg;

    typedef enum logic [1:0] {
        AM_DIRECT = 2'b00,
        AM_PTR_B  = 2'b01,
        AM_PTR_X  = 2'b10,
        AM_PTR_SP = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        PM_NONE = 2'b00,
        PM_INC  = 2'b01,
        PM_DEC  = 2'b10,
        PM_RSVD = 2'b11
    } pmod_e;

    typedef enum logic [1:0] {
        RS_ZERO = 2'b00,
        RS_REG  = 2'b01,
        RS_RAM  = 2'b10
    } rsrc_e;

    localparam int unsigned RF_DEPTH = 16;
    localparam int unsigned RF_IDX_W = $clog2(RF_DEPTH);
    localparam logic [3:0]  RF_PAGE  = 4'hF;

    // Pointer slots inside the register file (behaviour depends on these)
    localparam logic [RF_IDX_W-1:0] IDX_X  = 4'hC;
    localparam logic [RF_IDX_W-1:0] IDX_SP = 4'hD;
    localparam logic [RF_IDX_W-1:0] IDX_B  = 4'hE;
    localparam logic [RF_IDX_W-1:0] IDX_S  = 4'hF;

endpackage

// File: rtl/segaddr_regfile.sv
// Module: segaddr_regfile
// Sixteen flop registers at the top of the data address range. Four of them
// hold the X, SP, B and S registers, which are visible on dedicated outputs.
// A write to a slot takes priority over a post-modify of the same slot.
// Assumes that at most one write arrives per cycle and that the post-modify
// codes are already qualified by the caller.
module segaddr_regfile
    import segaddr_pkg::*;
#(
    parameter int unsigned  DW       = 8,
    parameter logic [DW-1:0] SP_RESET = 8'h6F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [RF_IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]       wr_data,
    input  logic [RF_IDX_W-1:0] rd_idx,
    output logic [DW-1:0]       rd_data,
    input  pmod_e               pm_b,
    input  pmod_e               pm_x,
    output logic [DW-1:0]       ptr_b,
    output logic [DW-1:0]       ptr_x,
    output logic [DW-1:0]       ptr_sp,
    output logic [DW-1:0]       seg_s
);

    logic [RF_DEPTH-1:0][DW-1:0] flat;

    // Next value of a pointer after its post-modify
    function automatic logic [DW-1:0] stepped(input logic [DW-1:0] v, input pmod_e m);
        case (m)
            PM_INC:  return v + 1'b1;
            PM_DEC:  return v - 1'b1;
            default: return v;
        endcase
    endfunction

    for (genvar i = 0; i < RF_DEPTH; i++) begin : g_rf
        localparam logic [RF_IDX_W-1:0] MY_IDX  = RF_IDX_W'(i);
        localparam logic [DW-1:0]       RST_VAL = (MY_IDX == IDX_SP) ? SP_RESET : '0;
        localparam bit                  IS_B    = (MY_IDX == IDX_B);
        localparam bit                  IS_X    = (MY_IDX == IDX_X);
        logic [DW-1:0] q_r;

        // Per-slot update: reset, then direct write, then post-modify
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_r <= RST_VAL;
            end else if (wr_en && (wr_idx == MY_IDX)) begin
                q_r <= wr_data;
            end else if (IS_B) begin
                q_r <= stepped(q_r, pm_b);
            end else if (IS_X) begin
                q_r <= stepped(q_r, pm_x);
            end
        end

        assign flat[i] = q_r;
    end

    // Read port and pointer taps
    assign rd_data = flat[rd_idx];
    assign ptr_b   = flat[IDX_B];
    assign ptr_x   = flat[IDX_X];
    assign ptr_sp  = flat[IDX_SP];
    assign seg_s   = flat[IDX_S];

    // R1: reset values of the mapped registers
    p_reset_vals_r1: assert property (@(posedge clk)
        !rst_n |=> (ptr_sp == SP_RESET && ptr_b == '0 && ptr_x == '0 && seg_s == '0));

    // R7: B post-increment wraps modulo 256
    p_b_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_b == PM_INC && !(wr_en && wr_idx == IDX_B)) |=> ptr_b == DW'($past(ptr_b) + 1'b1));

    // R7: X post-decrement wraps modulo 256
    p_x_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_x == PM_DEC && !(wr_en && wr_idx == IDX_X)) |=> ptr_x == DW'($past(ptr_x) - 1'b1));

    // R9: a write to the B slot beats a concurrent post-modify
    p_b_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_B) |=> ptr_b == $past(wr_data));

    // R8: SP changes only through a write to its slot
    p_sp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == IDX_SP) |=> $stable(ptr_sp));

endmodule

// File: rtl/segaddr_xlate.sv
// Module: segaddr_xlate
// Combinational translation of an 8-bit effective address. Bit 7 set leaves
// the address unextended; bit 7 clear puts the segment register in front of
// the low seven bits. Also flags register-file hits and in-range RAM hits.
// Assumes RAM_BYTES does not exceed the physical address space.
module segaddr_xlate
    import segaddr_pkg::*;
#(
    parameter int unsigned SEG_W     = 8,
    parameter int unsigned RAM_BYTES = 512,
    localparam int unsigned PA_W     = SEG_W + 7,
    localparam int unsigned RAM_AW   = $clog2(RAM_BYTES)
) (
    input  logic [7:0]        eff_addr,
    input  logic [SEG_W-1:0]  seg,
    output logic [PA_W-1:0]   phys,
    output logic              is_reg,
    output logic              ram_hit,
    output logic [RAM_AW-1:0] ram_idx
);

    // Extension choice by address bit 7
    always_comb begin
        if (eff_addr[7]) begin
            phys = PA_W'(eff_addr);
        end else begin
            phys = {seg, eff_addr[6:0]};
        end
    end

    // Register-file page and RAM range decode
    assign is_reg  = (eff_addr[7:4] == RF_PAGE);
    assign ram_hit = !is_reg && (32'(phys) < RAM_BYTES);
    assign ram_idx = phys[RAM_AW-1:0];

endmodule

// File: rtl/segaddr_ram.sv
// Module: segaddr_ram
// Byte-wide RAM model with one synchronous port: writes land at the clock
// edge, and reads register the addressed byte. Contents are not reset.
// Assumes the caller never asserts read and write together.
module segaddr_ram #(
    parameter int unsigned DW        = 8,
    parameter int unsigned RAM_BYTES = 512,
    localparam int unsigned RAM_AW   = $clog2(RAM_BYTES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [RAM_AW-1:0] idx,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);

    logic [DW-1:0] mem [RAM_BYTES];

    // Storage write and registered read
    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
        if (re) begin
            rdata <= mem[idx];
        end
    end

endmodule

// File: rtl/segaddr_unit.sv
// Module: segaddr_unit (top)
// Selects the effective address (direct or B/X/SP), translates it through the
// segment logic, and steers the access to the register file, the RAM, or
// nowhere (out of range). Read results appear one cycle later.
// Assumes one request per cycle; post-modify applies to B and X only.
module segaddr_unit
    import segaddr_pkg::*;
#(
    parameter int unsigned RAM_BYTES = 512,
    parameter logic [7:0]  SP_RESET  = 8'h6F,
    localparam int unsigned DW       = 8,
    localparam int unsigned SEG_W    = 8,
    localparam int unsigned PA_W     = SEG_W + 7,
    localparam int unsigned RAM_AW   = $clog2(RAM_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [1:0]      req_mode,
    input  logic [1:0]      req_postmod,
    input  logic [7:0]      req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic [PA_W-1:0] phys_addr,
    output logic            rd_valid,
    output logic [DW-1:0]   rd_data
);

    amode_e            mode;
    pmod_e             pmod;
    logic [7:0]        eff_addr;
    logic [DW-1:0]     ptr_b, ptr_x, ptr_sp, seg_s;
    logic [DW-1:0]     rf_rd_data;
    logic              is_reg, ram_hit;
    logic [RAM_AW-1:0] ram_idx;
    logic [DW-1:0]     ram_rdata;
    pmod_e             pm_b, pm_x;
    logic              rd_req;
    logic              rd_valid_q;
    rsrc_e             src_q;
    logic [DW-1:0]     regval_q;

    assign mode   = amode_e'(req_mode);
    assign pmod   = pmod_e'(req_postmod);
    assign rd_req = req_valid && !req_write;

    // Effective address source selection
    always_comb begin
        case (mode)
            AM_PTR_B:  eff_addr = ptr_b;
            AM_PTR_X:  eff_addr = ptr_x;
            AM_PTR_SP: eff_addr = ptr_sp;
            default:   eff_addr = req_addr;
        endcase
    end

    // Post-modify qualified to valid B/X accesses
    assign pm_b = (req_valid && mode == AM_PTR_B) ? pmod : PM_NONE;
    assign pm_x = (req_valid && mode == AM_PTR_X) ? pmod : PM_NONE;

    segaddr_regfile #(
        .DW       (DW),
        .SP_RESET (SP_RESET)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (req_valid && req_write && is_reg),
        .wr_idx  (eff_addr[3:0]),
        .wr_data (req_wdata),
        .rd_idx  (eff_addr[3:0]),
        .rd_data (rf_rd_data),
        .pm_b    (pm_b),
        .pm_x    (pm_x),
        .ptr_b   (ptr_b),
        .ptr_x   (ptr_x),
        .ptr_sp  (ptr_sp),
        .seg_s   (seg_s)
    );

    segaddr_xlate #(
        .SEG_W     (SEG_W),
        .RAM_BYTES (RAM_BYTES)
    ) u_xlate (
        .eff_addr (eff_addr),
        .seg      (seg_s),
        .phys     (phys_addr),
        .is_reg   (is_reg),
        .ram_hit  (ram_hit),
        .ram_idx  (ram_idx)
    );

    segaddr_ram #(
        .DW        (DW),
        .RAM_BYTES (RAM_BYTES)
    ) u_ram (
        .clk   (clk),
        .we    (req_valid && req_write && ram_hit),
        .re    (rd_req && ram_hit),
        .idx   (ram_idx),
        .wdata (req_wdata),
        .rdata (ram_rdata)
    );

    // Read-return pipeline: remember the source and any register value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            src_q      <= RS_ZERO;
            regval_q   <= '0;
        end else begin
            rd_valid_q <= rd_req;
            if (rd_req) begin
                regval_q <= rf_rd_data;
                if (is_reg) begin
                    src_q <= RS_REG;
                end else if (ram_hit) begin
                    src_q <= RS_RAM;
                end else begin
                    src_q <= RS_ZERO;
                end
            end
        end
    end

    // Read data steering
    always_comb begin
        case (src_q)
            RS_REG:  rd_data = regval_q;
            RS_RAM:  rd_data = ram_rdata;
            default: rd_data = '0;
        endcase
    end

    assign rd_valid = rd_valid_q;

    // R11: a read request yields rd_valid next cycle
    p_rd_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    // R11: no rd_valid without a read request
    p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    // R10: out-of-range reads return zero
    p_oob_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !is_reg && !ram_hit) |=> rd_data == '0);

    // R4: register-file reads return the value held at the request
    p_reg_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && is_reg) |=> rd_data == $past(rf_rd_data));

endmodule

// File: tb/segaddr_unit_test.sv
module segaddr_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [1:0]  req_mode, req_postmod;
    logic [7:0]  req_addr, req_wdata;
    logic [14:0] phys_addr;
    logic        rd_valid;
    logic [7:0]  rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [1:0] M_DIR = 2'b00, M_B = 2'b01, M_X = 2'b10, M_SP = 2'b11;
    localparam logic [1:0] P_NO = 2'b00, P_INC = 2'b01, P_DEC = 2'b10, P_RSV = 2'b11;

    always #5 clk = ~clk;

    segaddr_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_mode    (req_mode),
        .req_postmod (req_postmod),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .phys_addr   (phys_addr),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One request cycle; called at a negedge, returns at the next negedge
    task automatic access(input logic [1:0] m, input logic [1:0] pm, input logic [7:0] a,
                          input logic w, input logic [7:0] d);
        req_valid = 1'b1; req_write = w; req_mode = m; req_postmod = pm;
        req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_postmod = P_NO; req_mode = M_DIR;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        access(M_DIR, P_NO, a, 1'b1, d);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        access(M_DIR, P_NO, a, 1'b0, 8'h00);
        chk(req, {8'h00, rd_data}, {8'h00, exp});
    endtask

    task automatic phys_chk(input string req, input logic [1:0] m, input logic [7:0] a,
                            input logic [14:0] exp);
        req_mode = m; req_addr = a;
        #1;
        chk(req, {1'b0, phys_addr}, {1'b0, exp});
        req_mode = M_DIR;
    endtask

    task automatic t_reset;
        chk("R1 rd_valid low in reset", {15'h0, rd_valid}, 16'h0);
        rd_chk("R1 SP reset", 8'hFD, 8'h6F);
        chk("R11 rd_valid after read", {15'h0, rd_valid}, 16'h1);
        rd_chk("R1 B reset", 8'hFE, 8'h00);
        rd_chk("R1 X reset", 8'hFC, 8'h00);
        rd_chk("R1 S reset", 8'hFF, 8'h00);
    endtask

    task automatic t_unext;
        wr(8'hFF, 8'h03);
        phys_chk("R2 phys unextended", M_DIR, 8'h90, 15'h0090);
        wr(8'h90, 8'hA5);
        rd_chk("R2 read unext S=3", 8'h90, 8'hA5);
        wr(8'hFF, 8'h00);
        rd_chk("R2 read unext S=0", 8'h90, 8'hA5);
    endtask

    task automatic t_segment;
        wr(8'hFF, 8'h00);
        wr(8'h10, 8'h11);
        wr(8'hFF, 8'h02);
        phys_chk("R3 phys segment 2", M_DIR, 8'h10, 15'h0110);
        wr(8'h10, 8'h3C);
        rd_chk("R3 seg 2 data", 8'h10, 8'h3C);
        wr(8'hFF, 8'h00);
        rd_chk("R3 seg 0 isolated", 8'h10, 8'h11);
    endtask

    task automatic t_regfile;
        wr(8'hFF, 8'h01);
        wr(8'h73, 8'h99);
        wr(8'hFF, 8'h00);
        phys_chk("R4 phys of reg page", M_DIR, 8'hF3, 15'h00F3);
        wr(8'hF3, 8'h77);
        rd_chk("R4 regfile byte", 8'hF3, 8'h77);
        wr(8'hFF, 8'h01);
        rd_chk("R4 RAM F3 untouched", 8'h73, 8'h99);
        wr(8'hFF, 8'h00);
    endtask

    task automatic t_indirect;
        wr(8'hFE, 8'h20);
        phys_chk("R5 B drives address", M_B, 8'h00, 15'h0020);
        access(M_B, P_INC, 8'h00, 1'b1, 8'h5A);
        rd_chk("R7 B post-inc", 8'hFE, 8'h21);
        rd_chk("R6 B write landed at old ptr", 8'h20, 8'h5A);
        wr(8'hFC, 8'h00);
        access(M_X, P_DEC, 8'h00, 1'b0, 8'h00);
        rd_chk("R7 X dec wraps", 8'hFC, 8'hFF);
        wr(8'hFC, 8'h30);
        wr(8'h30, 8'h6B);
        access(M_X, P_INC, 8'h00, 1'b0, 8'h00);
        chk("R7 X read uses old ptr", {8'h00, rd_data}, 16'h006B);
        rd_chk("R7 X post-inc", 8'hFC, 8'h31);
        wr(8'hFE, 8'hFF);
        access(M_B, P_INC, 8'h00, 1'b0, 8'h00);
        rd_chk("R7 B inc wraps", 8'hFE, 8'h00);
        wr(8'h6F, 8'hC3);
        access(M_SP, P_NO, 8'h00, 1'b0, 8'h00);
        chk("R6 SP indirect read", {8'h00, rd_data}, 16'h00C3);
    endtask

    task automatic t_ignored;
        access(M_SP, P_INC, 8'h00, 1'b0, 8'h00);
        rd_chk("R8 SP not modified", 8'hFD, 8'h6F);
        wr(8'hFE, 8'h40);
        access(M_DIR, P_INC, 8'h50, 1'b0, 8'h00);
        rd_chk("R8 direct leaves B", 8'hFE, 8'h40);
        access(M_B, P_RSV, 8'h00, 1'b0, 8'h00);
        rd_chk("R8 code 11 leaves B", 8'hFE, 8'h40);
    endtask

    task automatic t_write_wins;
        wr(8'hFE, 8'hFE);
        access(M_B, P_INC, 8'h00, 1'b1, 8'h44);
        rd_chk("R9 B write beats inc", 8'hFE, 8'h44);
        wr(8'hFC, 8'hFC);
        access(M_X, P_DEC, 8'h00, 1'b1, 8'h55);
        rd_chk("R9 X write beats dec", 8'hFC, 8'h55);
    endtask

    task automatic t_oob;
        wr(8'hFF, 8'h00);
        wr(8'h05, 8'h12);
        wr(8'hFF, 8'h04);
        phys_chk("R10 phys past RAM", M_DIR, 8'h05, 15'h0205);
        wr(8'h05, 8'hEE);
        rd_chk("R10 oob reads zero", 8'h05, 8'h00);
        wr(8'hFF, 8'h03);
        wr(8'h7F, 8'h81);
        rd_chk("R10 last byte 1FF in range", 8'h7F, 8'h81);
        wr(8'hFF, 8'h00);
        rd_chk("R10 oob write dropped", 8'h05, 8'h12);
    endtask

    task automatic t_latency;
        rd_chk("R11 prior read", 8'h90, 8'hA5);
        wr(8'h91, 8'h01);
        chk("R11 no rd_valid on write", {15'h0, rd_valid}, 16'h0);
        chk("R11 rd_data held", {8'h00, rd_data}, 16'h00A5);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_mode = M_DIR; req_postmod = P_NO; req_addr = 8'h00; req_wdata = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset_pre();
        rst_n = 1'b1;
        t_reset();
        t_unext();
        t_segment();
        t_regfile();
        t_indirect();
        t_ignored();
        t_write_wins();
        t_oob();
        t_latency();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic t_reset_pre;
        chk("R1 rd_valid low during reset", {15'h0, rd_valid}, 16'h0);
    endtask

endmodule